// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

A memory-mapped timer with two or three independent 32-bit channels that count down. Every channel owns a reload register, a count register and a control word. The control word picks the count clock (the peripheral clock divided by 4, 16, 64, 256 or 1024), enables an underflow interrupt, and holds a sticky underflow flag. One shared start register carries a run bit per channel.

When a running channel is at zero and its divided clock ticks, the count is refilled from the reload register and the flag is raised on that same tick. Each channel drives its own interrupt line. Software gets a rising time base by inverting the count. Software may also rewrite the count at any time for one-shot or periodic use.

Access is through a simple synchronous port. Writes take effect on the clock edge and honour byte enables. Read data is combinational from the address.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the start register reads 0, every count and reload register reads 0xFFFFFFFF, every control word reads 0, and all interrupt outputs are low.
- R2: Register byte offsets are as follows. The start register is at 4. Channel n's reload register is at 8+12n, its count register at 12+12n, and its control word at 16+12n. Data lies in the low bits of the 32-bit bus.
- R3: Start register bit n set makes channel n count down by one per divided tick. With bit n clear, the count holds.
- R4: Control bits [2:0] select the divider: code 0 gives /4, 1 gives /16, 2 gives /64, 3 gives /256, 4 gives /1024, and codes 5 to 7 give /4. The first tick after starting arrives exactly one divider period after the start write.
- R5: The divider of a channel restarts from zero whenever its run bit goes from 0 to 1.
- R6: A tick at count zero loads the count from the reload register and sets the flag (control bit 8) on that same edge.
- R7: Interrupt n is high exactly while channel n's flag and its enable (control bit 5) are both set.
- R8: A control write with bit 8 at 0 clears the flag. A write with bit 8 at 1 leaves it unchanged. An underflow on the same edge as a clearing write leaves the flag set.
- R9: A count write takes effect on its edge, even while running and even on a tick edge. A reload write does not change the count.
- R10: Writes update only the bytes whose byte enable is set.
- R11: The bitwise inverse of a running count increases over time.
- R12: Unimplemented bits read as zero. This covers start bits at and above the channel count, and control bits other than 8, 5 and [2:0]. Control code values 5 to 7 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
A software write to the control word can land on the same edge as a hardware underflow. The bench provokes this by starting a channel at count zero with the divide-by-4 tap, then issuing a flag-clearing write timed to the fourth edge. It expects the flag and interrupt to remain set. A write to the count register on a tick edge is also timed the same way. There the written value must be read back rather than the value minus one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int PS_W      = 10;
  localparam int SEL_W     = 3;
  localparam int CTRL_W    = 16;
  localparam int START_OFS = 4;
  localparam int CH_BASE   = 8;
  localparam int CH_STRIDE = 12;
  localparam int RELOAD_OFS = 0;
  localparam int COUNT_OFS  = 4;
  localparam int CTRL_OFS   = 8;
  localparam int FLAG_BIT  = 8;
  localparam int IE_BIT    = 5;

  function automatic int ch_ofs(input int ch, input int field);
    return CH_BASE + CH_STRIDE * ch + field;
  endfunction

  function automatic logic [PS_W-1:0] tap_mask(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    return PS_W'(15);
      3'd2:    return PS_W'(63);
      3'd3:    return PS_W'(255);
      3'd4:    return PS_W'(1023);
      default: return PS_W'(3);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] be_merge(input logic [DATA_W-1:0] old_v,
                                                 input logic [DATA_W-1:0] new_v,
                                                 input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_image(input logic flag, input logic ie,
                                                   input logic [SEL_W-1:0] code);
    logic [CTRL_W-1:0] r;
    r = '0;
    r[FLAG_BIT]    = flag;
    r[IE_BIT]      = ie;
    r[SEL_W-1:0]   = code;
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] code,
  output logic             tick
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;

  assign mask = tap_mask(code);

  // Held at zero while stopped, so a fresh start always begins a full period.
  always_ff @(posedge clk) begin
    if (!rst_n)    ps_q <= '0;
    else if (!run) ps_q <= '0;
    else           ps_q <= ps_q + PS_W'(1);
  end

  assign tick = run && ((ps_q & mask) == mask);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_rel,
  input  logic              wr_cnt,
  input  logic              wr_ctl,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rel,
  output logic [CTRL_W-1:0] ctl,
  output logic [SEL_W-1:0]  code,
  output logic              flag,
  output logic              unf,
  output logic              irq
);
  logic ie_q;

  assign unf = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '1;
      rel  <= '1;
      code <= '0;
      ie_q <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr_rel) rel <= be_merge(rel, wdata, be);
      if (wr_cnt)      cnt <= be_merge(cnt, wdata, be);
      else if (unf)    cnt <= rel;
      else if (tick)   cnt <= cnt - DATA_W'(1);
      if (wr_ctl && be[0]) begin
        code <= wdata[SEL_W-1:0];
        ie_q <= wdata[IE_BIT];
      end
      if (unf)                                       flag <= 1'b1;
      else if (wr_ctl && be[1] && !wdata[FLAG_BIT])  flag <= 1'b0;
    end
  end

  assign ctl = ctrl_image(flag, ie_q, code);
  assign irq = flag & ie_q;
endmodule

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 6
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_start,
  output logic              rd_start,
  output logic [NUM_CH-1:0] wr_rel,
  output logic [NUM_CH-1:0] wr_cnt,
  output logic [NUM_CH-1:0] wr_ctl,
  output logic [NUM_CH-1:0] rd_rel,
  output logic [NUM_CH-1:0] rd_cnt,
  output logic [NUM_CH-1:0] rd_ctl
);
  logic do_wr, do_rd;
  assign do_wr = sel && wr;
  assign do_rd = sel && !wr;

  assign wr_start = do_wr && (addr == ADDR_W'(START_OFS));
  assign rd_start = do_rd && (addr == ADDR_W'(START_OFS));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_REL = ADDR_W'(ch_ofs(i, RELOAD_OFS));
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ch_ofs(i, COUNT_OFS));
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ch_ofs(i, CTRL_OFS));
    assign wr_rel[i] = do_wr && (addr == A_REL);
    assign wr_cnt[i] = do_wr && (addr == A_CNT);
    assign wr_ctl[i] = do_wr && (addr == A_CTL);
    assign rd_rel[i] = do_rd && (addr == A_REL);
    assign rd_cnt[i] = do_rd && (addr == A_CNT);
    assign rd_ctl[i] = do_rd && (addr == A_CTL);
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic                          wr_start, rd_start;
  logic [NUM_CH-1:0]             wr_rel, wr_cnt, wr_ctl, rd_rel, rd_cnt, rd_ctl;
  logic [NUM_CH-1:0]             run_q;
  logic [NUM_CH-1:0]             tick_v, unf_v, flag_v;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_v, rel_v;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctl_v;
  logic [NUM_CH-1:0][SEL_W-1:0]  code_v;

  tmr_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wr_start(wr_start), .rd_start(rd_start),
    .wr_rel(wr_rel), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl),
    .rd_rel(rd_rel), .rd_cnt(rd_cnt), .rd_ctl(rd_ctl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    run_q <= '0;
    else if (wr_start && bus_be[0]) run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_prescale u_ps (
      .clk(clk), .rst_n(rst_n), .run(run_q[i]), .code(code_v[i]), .tick(tick_v[i])
    );
    tmr_chan u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick_v[i]),
      .wr_rel(wr_rel[i]), .wr_cnt(wr_cnt[i]), .wr_ctl(wr_ctl[i]),
      .be(bus_be), .wdata(bus_wdata),
      .cnt(cnt_v[i]), .rel(rel_v[i]), .ctl(ctl_v[i]), .code(code_v[i]),
      .flag(flag_v[i]), .unf(unf_v[i]), .irq(irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_start) bus_rdata = DATA_W'(run_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_rel[i]) bus_rdata = rel_v[i];
      if (rd_cnt[i]) bus_rdata = cnt_v[i];
      if (rd_ctl[i]) bus_rdata = DATA_W'(ctl_v[i]);
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       run,
  input logic [NUM_CH-1:0]       tick,
  input logic [NUM_CH-1:0]       unf,
  input logic [NUM_CH-1:0]       flag,
  input logic [NUM_CH-1:0]       irq,
  input logic [NUM_CH-1:0]       cnt_wr,
  input logic [NUM_CH-1:0]       ctl_wr,
  input logic [NUM_CH-1:0][31:0] cnt,
  input logic [NUM_CH-1:0][31:0] rel
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] |-> run[i]) else $error("tick while stopped"); // R4
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !cnt_wr[i]) |=> $stable(cnt[i])) else $error("count moved while stopped"); // R3
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && !unf[i] && !cnt_wr[i]) |=> (cnt[i] == $past(cnt[i]) - 32'd1)) else $error("bad decrement"); // R3
    AST_UNF_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (unf[i] && !cnt_wr[i]) |=> (cnt[i] == $past(rel[i]))) else $error("no reload"); // R6
    AST_UNF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      unf[i] |=> flag[i]) else $error("flag not set"); // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag[i]) else $error("irq without flag"); // R7
    AST_FLAG_CLR_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(ctl_wr[i] && !unf[i])) else $error("flag cleared without write"); // R8
  end
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_v), .unf(unf_v),
  .flag(flag_v), .irq(irq), .cnt_wr(wr_cnt), .ctl_wr(wr_ctl),
  .cnt(cnt_v), .rel(rel_v)
);

// File: tb/test_tmr_unit.sv
`timescale 1ns/1ps
module test_tmr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;
  logic [2:0]  irq_s;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_unit i_tmr_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam int A_START = 4;
  function automatic int a_rel(int n); return 8 + 12*n; endfunction
  function automatic int a_cnt(int n); return 12 + 12*n; endfunction
  function automatic int a_ctl(int n); return 16 + 12*n; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] be = 4'hF);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a);
    #1;
    d = bus_rdata;
    irq_s = irq;
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_START, d);  check("R1 start", d, 0);
    rd(a_cnt(0), d); check("R1 count", d, 32'hFFFF_FFFF);
    rd(a_rel(2), d); check("R1 reload", d, 32'hFFFF_FFFF);
    rd(a_ctl(1), d); check("R1 ctrl", d, 0);
    check("R1 irq", 32'(irq_s), 0);
  endtask

  task automatic t_map_bytes;
    logic [31:0] d;
    wr(a_rel(1), 32'h1234_5678);
    rd(a_rel(1), d); check("R2 reload map", d, 32'h1234_5678);
    rd(a_rel(0), d); check("R2 neighbour untouched", d, 32'hFFFF_FFFF);
    wr(a_cnt(2), 32'h0000_00AB, 4'b0001);
    rd(a_cnt(2), d); check("R10 byte enable", d, 32'hFFFF_FFAB);
    wr(a_ctl(2), 32'hFFFF_FFFF);
    rd(a_ctl(2), d); check("R12 ctrl spare bits", d, 32'h0000_0027);
    wr(a_ctl(2), 32'h0000_0000);
    wr(A_START, 32'hFF);
    rd(A_START, d); check("R12 start spare bits", d, 32'h7);
    wr(A_START, 0);
  endtask

  task automatic t_div4(logic [2:0] code, string req);
    logic [31:0] d, d2;
    wr(a_cnt(0), 100);
    wr(a_ctl(0), 32'(code));
    wr(A_START, 1);
    rd(a_cnt(0), d);  check({req, " no tick at start"}, d, 100);
    idle(2);
    rd(a_cnt(0), d);  check({req, " no tick before 4"}, d, 100);
    rd(a_cnt(0), d);  check({req, " first tick at 4"}, d, 99);
    idle(7);
    rd(a_cnt(0), d2); check({req, " R3 three ticks"}, d2, 97);
    check("R11 inverse rises", 32'(~d2 > ~d), 1);
    wr(A_START, 0);
    idle(20);
    rd(a_cnt(0), d);  check("R3 stopped holds", d, 97);
  endtask

  task automatic t_restart;
    logic [31:0] d;
    wr(a_ctl(0), 0);
    wr(a_cnt(0), 50);
    wr(A_START, 1);
    idle(1);
    wr(A_START, 0);
    wr(A_START, 1);
    rd(a_cnt(0), d); check("R5 restart", d, 50);
    idle(2);
    rd(a_cnt(0), d); check("R5 full period", d, 50);
    rd(a_cnt(0), d); check("R5 tick after 4", d, 49);
    wr(A_START, 0);
  endtask

  task automatic t_tap(logic [2:0] code, int div);
    logic [31:0] d;
    wr(a_cnt(0), 0);
    wr(a_rel(0), 5);
    wr(a_ctl(0), 32'(code));
    wr(A_START, 1);
    idle(div - 1);
    rd(a_ctl(0), d); check($sformatf("R4 code %0d before tick", code), d, 32'(code));
    rd(a_ctl(0), d); check($sformatf("R6 code %0d flag on tick", code), d, 32'(code) | 32'h100);
    check("R7 irq off without enable", 32'(irq_s), 0);
    rd(a_cnt(0), d); check($sformatf("R6 code %0d reload", code), d, 5);
    wr(A_START, 0);
    wr(a_ctl(0), 0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    wr(a_cnt(0), 0);
    wr(a_rel(0), 9);
    wr(a_ctl(0), 32'h20);
    wr(A_START, 1);
    idle(3);
    wr(a_ctl(0), 32'h20, 4'b0011);
    rd(a_ctl(0), d); check("R8 underflow beats clear", d, 32'h120);
    check("R7 irq set", 32'(irq_s), 1);
    wr(a_ctl(0), 32'h120);
    rd(a_ctl(0), d); check("R8 write one keeps flag", d, 32'h120);
    wr(a_ctl(0), 32'h20);
    rd(a_ctl(0), d); check("R8 write zero clears", d, 32'h20);
    check("R7 irq cleared", 32'(irq_s), 0);
    wr(A_START, 0);
    wr(a_ctl(0), 0);
  endtask

  task automatic t_cnt_write;
    logic [31:0] d;
    wr(a_cnt(0), 20);
    wr(A_START, 1);
    idle(3);
    wr(a_cnt(0), 500);
    rd(a_cnt(0), d); check("R9 write wins on tick", d, 500);
    wr(A_START, 0);
    wr(a_cnt(0), 300);
    wr(a_rel(0), 7);
    rd(a_cnt(0), d); check("R9 reload write no effect", d, 300);
  endtask

  task automatic t_indep;
    logic [31:0] d;
    wr(a_cnt(0), 1234);
    wr(a_cnt(1), 0);
    wr(a_ctl(1), 32'h20);
    wr(A_START, 32'h2);
    idle(4);
    rd(a_cnt(0), d); check("R3 other channel idle", d, 1234);
    check("R7 only channel 1 irq", 32'(irq_s), 32'h2);
    wr(A_START, 0);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_map_bytes();
    t_div4(3'd0, "R4 code0");
    t_div4(3'd5, "R4 code5");
    t_restart();
    t_tap(3'd0, 4);
    t_tap(3'd1, 16);
    t_tap(3'd2, 64);
    t_tap(3'd3, 256);
    t_tap(3'd4, 1024);
    t_collision();
    t_cnt_write();
    t_indep();
    done = 1;
    summary();
  end
endmodule